// File: doc/BRIEF.md
# Double-Data-Rate Two-Word-Burst SRAM Model

This block is a synthesizable, scaled-down model of a quad-data-rate static memory with a write data port and a separate read data port. Every access moves a two-word burst. It runs from one clock at twice the rate of the device clock K. Each period of K is split into a K half and a K# half. An internal phase machine tracks the halves and reports them on `k_half`, which is high when the next rising edge of `clk` is a K edge. The same machine drives the free-running echo clock pair.

A single address bus is shared at double data rate. The read address is taken on the K edge and the write address on the K# edge of the same K cycle. Write data and the byte-write enables are taken on both edges. The two words of a burst are merged into one storage word of twice the data width, with the first word in the low half. Read bursts return on `q` after a fixed latency of three half-cycles. The first word appears after the K# edge and the second after the following K edge. While no read beat is present, `q` is high impedance.

A read and a write may start in the same K cycle. When they target the same location, the read returns the newly merged data.

The phase machine has two states. `PH_K` means the next edge is a K edge; it always moves to `PH_KN`. `PH_KN` means the next edge is a K# edge; it always moves back to `PH_K`. The read output machine has three states:
- `OS_IDLE` moves to `OS_FIRST` when a burst leaves the delay line, and otherwise stays in `OS_IDLE`.
- `OS_FIRST` always moves to `OS_SECOND`.
- `OS_SECOND` moves to `OS_FIRST` if another burst leaves the delay line, and otherwise returns to `OS_IDLE`.

Top module: `qdrb2_sram`

## Requirements
- R1: `rd_n` and `wr_n` are active low and are sampled only on K edges. Their levels during the K# half have no effect. A read and a write started in the same K cycle are both performed.
- R2: The read address is taken on the K edge and the write address on the K# edge. When a port is deselected, the address and data presented for it leave the memory contents and the outputs unchanged.
- R3: Write word 0 and its enables are taken on the K edge, and word 1 and its enables on the K# edge. A later read returns word 0 as the first beat and word 1 as the second beat.
- R4: `bw_n` is active low. Bit i of `bw_n` covers bits 9*i+8 down to 9*i of the beat it is sampled with. Lanes that are not enabled keep their stored value.
- R5: When `bw_n` is all ones for one beat of a write, that word of the location stays unchanged, while the other beat is still written.
- R6: A read and a write to the same address in the same K cycle return the newly written data, merged according to the byte enables.
- R7: For a read sampled on K edge n, the first word is on `q` after clk edge n+3 (a K# edge) and the second word after edge n+4. `q_valid` is high for exactly those two half-cycles.
- R8: `q` is high impedance and `q_valid` is low whenever no read beat is present, including after reset and after the last beat of a burst. Reads in consecutive K cycles give an unbroken run of valid beats.
- R9: After each K edge, `cq`=1 and `cq_n`=0. After each K# edge, `cq`=0 and `cq_n`=1. The pair toggles at all times, even while `q` is high impedance.
- R10: During reset, `k_half`=1, `cq`=0, `cq_n`=1 and `q_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the K rate |
| rst | input | 1 | Synchronous reset, active high |
| rd_n | input | 1 | Read select, active low, sampled on K edges |
| wr_n | input | 1 | Write select, active low, sampled on K edges |
| addr | input | $clog2(DEPTH) | Read address in the K half, write address in the K# half |
| wdata | input | NBYTE*BYTE_W | Write word 0 in the K half, word 1 in the K# half |
| bw_n | input | NBYTE | Byte-lane write enables, active low, one per beat |
| q | output | NBYTE*BYTE_W | Read data, high impedance when no beat is present |
| q_valid | output | 1 | High while `q` carries a read beat |
| cq | output | 1 | Echo clock, rises after K edges |
| cq_n | output | 1 | Complementary echo clock, rises after K# edges |
| k_half | output | 1 | High when the next clk edge is a K edge |

## Verification
A phase machine that slips by one state swaps the K and K# roles. The echo pair then disagrees with `k_half` on the very next half-cycle, and writes pick up the wrong address. A fault in the read delay line or the output machine shows on the first read burst: a valid beat three or four half-cycles off, a missing second beat, or beats in swapped order. A fault in the merge or forwarding path shows at the first read of a location touched by a partial write, in the lanes whose enables were off.

// File: rtl/qdrb2_pkg.sv
package qdrb2_pkg;
    // Half-cycle phase of the K clock as seen by the next clk edge.
    typedef enum logic {
        PH_K  = 1'b0,
        PH_KN = 1'b1
    } phase_e;

    // Read output sequencing.
    typedef enum logic [1:0] {
        OS_IDLE   = 2'd0,
        OS_FIRST  = 2'd1,
        OS_SECOND = 2'd2
    } ostate_e;
endpackage

// File: rtl/qdrb2_phase.sv
module qdrb2_phase
    import qdrb2_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output logic at_k,
    output logic cq,
    output logic cq_n
);
    phase_e ph_q, ph_nxt;

    always_comb begin
        unique case (ph_q)
            PH_K:    ph_nxt = PH_KN;
            PH_KN:   ph_nxt = PH_K;
            default: ph_nxt = PH_K;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_K;
        else     ph_q <= ph_nxt;
    end

    // Echo outputs: K edge raises cq and drops cq_n, K# edge the reverse.
    always_ff @(posedge clk) begin
        if (rst) begin
            cq   <= 1'b0;
            cq_n <= 1'b1;
        end else begin
            unique case (ph_q)
                PH_K: begin
                    cq   <= 1'b1;
                    cq_n <= 1'b0;
                end
                PH_KN: begin
                    cq   <= 1'b0;
                    cq_n <= 1'b1;
                end
                default: begin
                    cq   <= 1'b0;
                    cq_n <= 1'b1;
                end
            endcase
        end
    end

    assign at_k = (ph_q == PH_K);

    // R9
    echo_compl_chk: assert property (@(posedge clk) disable iff (rst) cq != cq_n);
endmodule

// File: rtl/qdrb2_array.sv
module qdrb2_array #(
    parameter int W     = 18,
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [AW-1:0]  waddr,
    input  logic [2*W-1:0] wdata2,
    input  logic [2*W-1:0] wmask2,
    input  logic           re,
    input  logic [AW-1:0]  raddr,
    output logic           rd_v,
    output logic [2*W-1:0] rd_data
);
    logic [2*W-1:0] mem [DEPTH];
    logic [2*W-1:0] merged;

    assign merged = (mem[waddr] & ~wmask2) | (wdata2 & wmask2);

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= merged;
    end

    always_ff @(posedge clk) begin
        if (rst) rd_v <= 1'b0;
        else     rd_v <= re;
    end

    // Same-edge read of the location being written sees the merged word.
    always_ff @(posedge clk) begin
        if (re) rd_data <= (we && (waddr == raddr)) ? merged : mem[raddr];
    end
endmodule

// File: rtl/qdrb2_rdpipe.sv
module qdrb2_rdpipe
    import qdrb2_pkg::*;
#(
    parameter int W   = 18,
    parameter int DLY = 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_v,
    input  logic [2*W-1:0] in_data,
    output logic [W-1:0]   q_data,
    output logic           q_valid
);
    logic [DLY-1:0] v_sh;
    logic [2*W-1:0] d_sh [DLY];
    logic           end_v;
    logic [2*W-1:0] end_d;
    logic [W-1:0]   hold_r;
    ostate_e        ost_q, ost_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_sh <= '0;
        end else begin
            v_sh[0] <= in_v;
            for (int i = 1; i < DLY; i++) v_sh[i] <= v_sh[i-1];
        end
    end

    always_ff @(posedge clk) begin
        d_sh[0] <= in_data;
        for (int i = 1; i < DLY; i++) d_sh[i] <= d_sh[i-1];
    end

    assign end_v = v_sh[DLY-1];
    assign end_d = d_sh[DLY-1];

    always_comb begin
        unique case (ost_q)
            OS_IDLE:   ost_nxt = end_v ? OS_FIRST : OS_IDLE;
            OS_FIRST:  ost_nxt = OS_SECOND;
            OS_SECOND: ost_nxt = end_v ? OS_FIRST : OS_IDLE;
            default:   ost_nxt = OS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ost_q <= OS_IDLE;
        else     ost_q <= ost_nxt;
    end

    always_ff @(posedge clk) begin
        if (end_v) begin
            q_data <= end_d[W-1:0];
            hold_r <= end_d[2*W-1:W];
        end else if (ost_q == OS_FIRST) begin
            q_data <= hold_r;
        end
    end

    assign q_valid = (ost_q != OS_IDLE);

    // R7
    beat_pair_chk: assert property (@(posedge clk) disable iff (rst) $rose(q_valid) |=> q_valid);
    // R8
    pipe_no_overlap_chk: assert property (@(posedge clk) disable iff (rst) end_v |-> (ost_q != OS_FIRST));
endmodule

// File: rtl/qdrb2_sram.sv
module qdrb2_sram #(
    parameter int NBYTE       = 2,
    parameter int BYTE_W      = 9,
    parameter int DEPTH       = 256,
    parameter int RD_LAT_HALF = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      rd_n,
    input  logic                      wr_n,
    input  logic [$clog2(DEPTH)-1:0]  addr,
    input  logic [NBYTE*BYTE_W-1:0]   wdata,
    input  logic [NBYTE-1:0]          bw_n,
    output logic [NBYTE*BYTE_W-1:0]   q,
    output logic                      q_valid,
    output logic                      cq,
    output logic                      cq_n,
    output logic                      k_half
);
    localparam int W        = NBYTE * BYTE_W;
    localparam int AW       = $clog2(DEPTH);
    localparam int LANES    = 2 * NBYTE;
    localparam int PIPE_DLY = RD_LAT_HALF - 2;

    logic             rd_pend, wr_pend;
    logic [AW-1:0]    raddr_q;
    logic [W-1:0]     w0_q;
    logic [NBYTE-1:0] be0_q;
    logic [LANES-1:0] lane_en;
    logic [2*W-1:0]   wmask2;
    logic             commit_we, commit_re;
    logic             rd_v;
    logic [2*W-1:0]   rd_data;
    logic [W-1:0]     q_data;

    qdrb2_phase u_phase (
        .clk  (clk),
        .rst  (rst),
        .at_k (k_half),
        .cq   (cq),
        .cq_n (cq_n)
    );

    // K-edge capture of selects, read address, first write beat.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pend <= 1'b0;
            wr_pend <= 1'b0;
        end else if (k_half) begin
            rd_pend <= ~rd_n;
            wr_pend <= ~wr_n;
        end
    end

    always_ff @(posedge clk) begin
        if (k_half) begin
            raddr_q <= addr;
            w0_q    <= wdata;
            be0_q   <= ~bw_n;
        end
    end

    // Second beat enables come straight from the pins at the K# edge.
    assign lane_en = {~bw_n, be0_q};

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign wmask2[b*BYTE_W +: BYTE_W] = {BYTE_W{lane_en[b]}};
    end

    assign commit_we = wr_pend & ~k_half;
    assign commit_re = rd_pend & ~k_half;

    qdrb2_array #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_array (
        .clk     (clk),
        .rst     (rst),
        .we      (commit_we),
        .waddr   (addr),
        .wdata2  ({wdata, w0_q}),
        .wmask2  (wmask2),
        .re      (commit_re),
        .raddr   (raddr_q),
        .rd_v    (rd_v),
        .rd_data (rd_data)
    );

    qdrb2_rdpipe #(.W(W), .DLY(PIPE_DLY)) u_rdpipe (
        .clk     (clk),
        .rst     (rst),
        .in_v    (rd_v),
        .in_data (rd_data),
        .q_data  (q_data),
        .q_valid (q_valid)
    );

    assign q = q_valid ? q_data : 'z;

    // R7
    beat0_phase_chk: assert property (@(posedge clk) disable iff (rst) $rose(q_valid) |-> !cq);
endmodule

// File: tb/qdrb2_sram_tb.sv
module qdrb2_sram_tb_top;
    localparam int W = 18;

    typedef struct {
        logic [W-1:0] d;
        int           due;
        string        tag;
    } beat_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0]   addr = '0;
    logic [W-1:0] wdata = '0;
    logic [1:0]   bw_n = 2'b11;
    wire  [W-1:0] q;
    logic         q_valid, cq, cq_n, k_half;

    int checks = 0, errors = 0, cnt = 0;
    bit done = 0;
    beat_t exp_q[$];
    logic [2*W-1:0] ref_mem [256];

    qdrb2_sram dut_i (
        .clk(clk), .rst(rst), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
        .wdata(wdata), .bw_n(bw_n), .q(q), .q_valid(q_valid),
        .cq(cq), .cq_n(cq_n), .k_half(k_half)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cnt <= cnt + 1;

    function automatic logic [W-1:0] lane_mask(input logic [1:0] be);
        return {{9{be[1]}}, {9{be[0]}}};
    endfunction

    // Monitor: compares beats against the scoreboard and the echo pair.
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (cq !== ~k_half || cq_n !== k_half) begin
                errors++;
                $display("FAIL R9 echo cq=%b cq_n=%b expected %b %b", cq, cq_n, ~k_half, k_half);
            end
            if (q_valid === 1'b1) begin
                checks++;
                if (exp_q.size() == 0 || exp_q[0].due != cnt) begin
                    errors++;
                    $display("FAIL R7 unexpected beat %h at edge %0d", q, cnt);
                end else begin
                    if (q !== exp_q[0].d) begin
                        errors++;
                        $display("FAIL %s beat %h expected %h", exp_q[0].tag, q, exp_q[0].d);
                    end
                    void'(exp_q.pop_front());
                end
            end else begin
                checks++;
                if (exp_q.size() != 0 && exp_q[0].due == cnt) begin
                    errors++;
                    $display("FAIL R7 missing beat expected %h at edge %0d", exp_q[0].d, cnt);
                    void'(exp_q.pop_front());
                end else if (q !== 18'hzzzzz) begin
                    errors++;
                    $display("FAIL R8 q=%h expected high impedance", q);
                end
            end
        end
    end

    // One K cycle; called at a negedge where the next edge is a K edge.
    task automatic kcycle(input bit rd, input int ra, input bit wr, input int wa,
                          input logic [W-1:0] w0, input logic [1:0] be0,
                          input logic [W-1:0] w1, input logic [1:0] be1, input string tag);
        int n;
        logic [2*W-1:0] word;
        beat_t b;
        n = cnt + 1;
        rd_n = ~rd; wr_n = ~wr; addr = ra[7:0]; wdata = w0; bw_n = ~be0;
        @(negedge clk);
        // R1: selects driven low in the K# half must be ignored
        rd_n = 1'b0; wr_n = 1'b0; addr = wa[7:0]; wdata = w1; bw_n = ~be1;
        if (wr) begin
            word = ref_mem[wa];
            word[W-1:0]   = (word[W-1:0] & ~lane_mask(be0)) | (w0 & lane_mask(be0));
            word[2*W-1:W] = (word[2*W-1:W] & ~lane_mask(be1)) | (w1 & lane_mask(be1));
            ref_mem[wa] = word;
        end
        if (rd) begin
            word = ref_mem[ra];
            b.d = word[W-1:0];   b.due = n + 3; b.tag = tag; exp_q.push_back(b);
            b.d = word[2*W-1:W]; b.due = n + 4; b.tag = tag; exp_q.push_back(b);
        end
        @(negedge clk);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++)
            kcycle(0, 8'hA5 + i, 0, 8'h5A + i, 18'h2AAAA, 2'b11, 18'h15555, 2'b11, "R2");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        // R10 reset state, R8 high impedance during reset
        checks++;
        if (k_half !== 1'b1 || cq !== 1'b0 || cq_n !== 1'b1 || q_valid !== 1'b0) begin
            errors++;
            $display("FAIL R10 reset k_half=%b cq=%b cq_n=%b q_valid=%b expected 1 0 1 0",
                     k_half, cq, cq_n, q_valid);
        end
        checks++;
        if (q !== 18'hzzzzz) begin
            errors++;
            $display("FAIL R8 reset q=%h expected high impedance", q);
        end
        rst = 1'b0;
        while (k_half !== 1'b1) @(negedge clk);
        // Initialise the locations used below
        kcycle(0, 0, 1, 20, 18'h0, 2'b11, 18'h0, 2'b11, "R3");
        // R3 full write then read, beat order
        kcycle(0, 0, 1, 3, 18'h12345, 2'b11, 18'h2ABCD, 2'b11, "R3");
        kcycle(1, 3, 0, 0, 18'h0, 2'b00, 18'h0, 2'b00, "R3");
        idle(2);
        // R4 partial lanes
        kcycle(0, 0, 1, 7, 18'h3FFFF, 2'b11, 18'h00000, 2'b11, "R4");
        kcycle(0, 0, 1, 7, 18'h00000, 2'b01, 18'h3FFFF, 2'b10, "R4");
        kcycle(1, 7, 0, 0, 18'h0, 2'b00, 18'h0, 2'b00, "R4");
        idle(2);
        // R5 suppressed second word
        kcycle(0, 0, 1, 9, 18'h11111, 2'b11, 18'h22222, 2'b11, "R5");
        kcycle(0, 0, 1, 9, 18'h0ABCD, 2'b11, 18'h3FFFF, 2'b00, "R5");
        kcycle(1, 9, 0, 0, 18'h0, 2'b00, 18'h0, 2'b00, "R5");
        idle(2);
        // R6 same-cycle read and partial write to one address
        kcycle(1, 7, 1, 7, 18'h155AA, 2'b10, 18'h0F0F0, 2'b01, "R6");
        idle(2);
        // R1 read and write to different addresses in one K cycle
        kcycle(1, 3, 1, 20, 18'h31313, 2'b11, 18'h04040, 2'b11, "R1");
        kcycle(1, 20, 0, 0, 18'h0, 2'b00, 18'h0, 2'b00, "R1");
        idle(2);
        // R2 deselected write with live-looking address and data
        kcycle(0, 3, 0, 3, 18'h3FFFF, 2'b11, 18'h3FFFF, 2'b11, "R2");
        kcycle(1, 3, 0, 9, 18'h0, 2'b11, 18'h0, 2'b11, "R2");
        idle(2);
        // R8 back-to-back reads form an unbroken run
        kcycle(1, 3, 0, 0, 18'h0, 2'b00, 18'h0, 2'b00, "R8");
        kcycle(1, 7, 0, 0, 18'h0, 2'b00, 18'h0, 2'b00, "R8");
        kcycle(1, 9, 0, 0, 18'h0, 2'b00, 18'h0, 2'b00, "R8");
        kcycle(1, 20, 0, 0, 18'h0, 2'b00, 18'h0, 2'b00, "R8");
        idle(4);
        done = 1;
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R7 %0d beats never seen expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        done = 1;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule